// File: doc/BRIEF.md
# Bit-Select Wrap PWM Generator

This block produces one pulse-width-modulated output from a single free-running up-counter. The counter advances only on cycles where a slow tick enable is asserted. Normally that tick is a 32 kHz strobe made elsewhere on the chip. The period is not held in a register. A two-bit rate field picks which counter bit acts as the wrap trigger, and this gives periods of 128, 64, 32 or 16 ticks. With a 32 kHz tick these are 2 kHz, 1 kHz, 500 Hz and 250 Hz, from the fastest rate setting to the slowest.

The low counter bits below the wrap bit form the active count. The output is high while that count is strictly below a 7-bit duty value. Two byte-wide registers set the behaviour, and each is picked by a one-bit address:

- The control register holds an enable bit and the rate field.
- The duty register holds the duty value.

Register updates apply at once. A rate change leaves the counter where it is, and a duty change acts on the very next comparison. Clearing the enable gives up the pin through an ownership output, so the pin can fall back to another function.

Top module: `rstbit_pwm`

## Requirements
- R1: A synchronous reset clears the counter, the control register and the duty register. After reset, both registers read 0x00, the output is low and the ownership output is low.
- R2: The counter advances by exactly one on a clock edge where `tick_en` is high. With `tick_en` low it holds its value.
- R3: With rate field p, the counter loads zero instead of a value whose bit (7−p) is set. Starting from zero, the period is 128, 64, 32 or 16 ticks for p = 0, 1, 2, 3.
- R4: While enabled, `pwm_out` is high exactly when the counter's low (7−p) bits, read as a number, are below the duty value. A duty at or above the period length keeps the output high for the whole period.
- R5: At rate 0 the output is low whenever the active count is 127, so at most 127 of 128 ticks are high for any duty value. At rate 1, a duty of 64 keeps the output high for all 64 ticks.
- R6: A write to address 0 stores data bit 7 as the enable and data bits 1:0 as the rate field. A read of address 0 returns those bits in the same positions, with all other bits zero.
- R7: A write to address 1 stores data bits 6:0 as the duty value, and data bit 7 is ignored. A read of address 1 returns the duty with bit 7 zero.
- R8: Writing a new rate value leaves the counter unchanged. Counting continues under the new wrap rule. For example, count 40 under rate 3 reaches zero after 8 more ticks.
- R9: A new duty value affects `pwm_out` in the cycle right after the write, in the middle of a period.
- R10: `pin_own` equals the enable bit. While the enable is clear, `pwm_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count enable strobe (slow tick) |
| bus_addr | input | 1 | Register select: 0 control, 1 duty |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| pwm_out | output | 1 | Modulated output |
| pin_own | output | 1 | High while the generator owns the pin |

## Verification
The hardest state to reach is a counter whose value lies outside the active range of the current rate field. This only happens when the rate is rewritten mid-count, because the counter is never cleared by that write. The bench counts to 40 at the slowest rate and then switches to the fastest. It checks that the output reflects the low four bits and that the counter reaches zero only after eight further ticks. Mid-period duty updates are reached the same way: the bench stops ticking partway through a period and writes the duty there.

// File: rtl/rstbit_pwm_pkg.sv
package rstbit_pwm_pkg;

  // Register select values on the one-bit address
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DUTY = 1'b1
  } reg_sel_e;

  // Bit position of the enable flag inside the control byte
  localparam int unsigned EN_POS = 7;

  // Counter bit that triggers the wrap for a given rate value
  function automatic int unsigned wrap_bit_idx(int unsigned cnt_w, int unsigned rate);
    return cnt_w - 1 - rate;
  endfunction

  // Number of ticks in one period for a given rate value
  function automatic int unsigned period_ticks(int unsigned cnt_w, int unsigned rate);
    return 1 << wrap_bit_idx(cnt_w, rate);
  endfunction

endpackage

// File: rtl/rstbit_pwm_counter.sv
module rstbit_pwm_counter
  import rstbit_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] rate,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt,
  output logic [CNT_W-2:0] active_cnt
);
  localparam int unsigned NSEL = 1 << SEL_W;
  localparam int unsigned AW   = CNT_W - 1;

  logic [CNT_W-1:0] cnt_inc;
  logic [NSEL-1:0]  hit_vec;
  logic [AW-1:0]    mask_tab [NSEL];

  assign cnt_inc = cnt_q + CNT_W'(1);

  // One wrap candidate and one active-bit mask per rate value
  for (genvar s = 0; s < NSEL; s++) begin : g_rate
    assign hit_vec[s]  = cnt_inc[wrap_bit_idx(CNT_W, s)];
    assign mask_tab[s] = {AW{1'b1}} >> s;
  end

  assign wrap_evt   = hit_vec[rate];
  assign active_cnt = cnt_q[AW-1:0] & mask_tab[rate];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      cnt_q <= wrap_evt ? '0 : cnt_inc;
    end
  end
endmodule

// File: rtl/rstbit_pwm_regs.sv
module rstbit_pwm_regs
  import rstbit_pwm_pkg::*;
#(
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              en_q,
  output logic [SEL_W-1:0]  rate_q,
  output logic [DUTY_W-1:0] duty_q,
  output logic              ctrl_wr,
  output logic              duty_wr
);
  reg_sel_e sel;

  assign sel     = reg_sel_e'(bus_addr);
  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
  assign duty_wr = bus_wr && (sel == SEL_DUTY);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      rate_q <= '0;
      duty_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= bus_wdata[EN_POS];
        rate_q <= bus_wdata[SEL_W-1:0];
      end
      if (duty_wr) begin
        duty_q <= bus_wdata[DUTY_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel == SEL_CTRL) begin
      bus_rdata[EN_POS]      = en_q;
      bus_rdata[SEL_W-1:0]   = rate_q;
    end else begin
      bus_rdata[DUTY_W-1:0]  = duty_q;
    end
  end
endmodule

// File: rtl/rstbit_pwm_cmp.sv
module rstbit_pwm_cmp #(
  parameter int unsigned AW = 7
) (
  input  logic          en,
  input  logic [AW-1:0] active_cnt,
  input  logic [AW-1:0] duty,
  output logic          cmp_hit,
  output logic          pwm_out,
  output logic          pin_own
);
  assign cmp_hit = active_cnt < duty;
  assign pwm_out = en & cmp_hit;
  assign pin_own = en;
endmodule

// File: rtl/rstbit_pwm.sv
module rstbit_pwm #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_en,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       pwm_out,
  output logic       pin_own
);
  localparam int unsigned DUTY_W = CNT_W - 1;

  logic              en_q;
  logic [SEL_W-1:0]  rate_q;
  logic [DUTY_W-1:0] duty_q;
  logic              ctrl_wr;
  logic              duty_wr;
  logic [CNT_W-1:0]  cnt_q;
  logic              wrap_evt;
  logic [DUTY_W-1:0] active_cnt;
  logic              cmp_hit;

  rstbit_pwm_regs #(.SEL_W(SEL_W), .DUTY_W(DUTY_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .en_q(en_q),
    .rate_q(rate_q), .duty_q(duty_q), .ctrl_wr(ctrl_wr), .duty_wr(duty_wr)
  );

  rstbit_pwm_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rate(rate_q),
    .cnt_q(cnt_q), .wrap_evt(wrap_evt), .active_cnt(active_cnt)
  );

  rstbit_pwm_cmp #(.AW(DUTY_W)) u_cmp (
    .en(en_q), .active_cnt(active_cnt), .duty(duty_q),
    .cmp_hit(cmp_hit), .pwm_out(pwm_out), .pin_own(pin_own)
  );
endmodule

// File: rtl/rstbit_pwm_chk.sv
module rstbit_pwm_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             bus_wr,
  input logic             bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wrap_evt,
  input logic [SEL_W-1:0] rate_q,
  input logic [CNT_W-2:0] duty_q,
  input logic             pwm_out,
  input logic             pin_own
);
  localparam logic [CNT_W-2:0] TOP_ACTIVE = '1;

  // R1: reset leaves counter clear and pin released
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && !pin_own && !pwm_out));

  // R2: counter holds without a tick
  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt_q));

  // R2: counter steps by one on a tick that does not wrap
  assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !wrap_evt) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R3: a wrap event returns the counter to zero
  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && wrap_evt) |=> (cnt_q == '0));

  // R5: slowest rate never drives high at the top active count
  assert_no_full_duty_R5: assert property (@(posedge clk) disable iff (rst)
    (rate_q == '0 && cnt_q[CNT_W-2:0] == TOP_ACTIVE) |-> !pwm_out);

  // R6: control write sets ownership from data bit 7
  assert_ctrl_write_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr) |=> (pin_own == $past(bus_wdata[7])));

  // R7: duty write stores the low data bits
  assert_duty_write_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr) |=> (duty_q == $past(bus_wdata[CNT_W-2:0])));

  // R8: rate write without a tick keeps the counter
  assert_rate_keeps_count_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr && !tick_en) |=> (cnt_q == $past(cnt_q)));

  // R10: output is never high while the pin is released
  assert_gated_output_R10: assert property (@(posedge clk) disable iff (rst)
    !pin_own |-> !pwm_out);
endmodule

bind rstbit_pwm rstbit_pwm_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_q(cnt_q),
  .wrap_evt(wrap_evt), .rate_q(rate_q), .duty_q(duty_q),
  .pwm_out(pwm_out), .pin_own(pin_own)
);

// File: tb/rstbit_pwm_tb.sv
module rstbit_pwm_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       pwm_out;
  logic       pin_own;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  rstbit_pwm u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .pin_own(pin_own)
  );

  // Vector: {enable, rate[1:0], duty[6:0], high ticks per period[7:0]}
  localparam int NVEC = 12;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 7'd0,   8'd0},
    {1'b1, 2'd0, 7'd1,   8'd1},
    {1'b1, 2'd0, 7'd64,  8'd64},
    {1'b1, 2'd0, 7'd127, 8'd127},
    {1'b1, 2'd1, 7'd64,  8'd64},
    {1'b1, 2'd1, 7'd100, 8'd64},
    {1'b1, 2'd2, 7'd10,  8'd10},
    {1'b1, 2'd2, 7'd31,  8'd31},
    {1'b1, 2'd3, 7'd15,  8'd15},
    {1'b1, 2'd3, 7'd16,  8'd16},
    {1'b1, 2'd3, 7'd0,   8'd0},
    {1'b0, 2'd2, 7'd20,  8'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output int v);
    @(negedge clk);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    do_reset();
    // R1: reset state
    rd(1'b0, v); chk("R1 ctrl read", v, 0);
    rd(1'b1, v); chk("R1 duty read", v, 0);
    chk("R1 pwm_out", int'(pwm_out), 0);
    chk("R1 pin_own", int'(pin_own), 0);

    // Table walk: R4 / R5 / R10, two periods each
    for (int i = 0; i < NVEC; i++) begin
      logic [17:0] e;
      int p; int per; int highs;
      string req;
      e = VEC[i];
      p = int'(e[16:15]);
      per = 1 << (7 - p);
      highs = 0;
      do_reset();
      wr(1'b0, {e[17], 5'b0, e[16:15]});
      wr(1'b1, {1'b0, e[14:8]});
      for (int k = 0; k < 2 * per; k++) begin
        if (pwm_out) highs++;
        tick(1);
      end
      if (!e[17]) req = "R10 disabled high count";
      else if ((p == 0 && e[14:8] == 7'd127) || (p == 1 && e[14:8] >= 7'd64))
        req = "R5 high count";
      else req = "R4 high count";
      chk(req, highs, 2 * int'(e[7:0]));
    end

    // R3: period per rate, duty 1 -> high only at count 0
    for (int p = 0; p < 4; p++) begin
      int n;
      do_reset();
      wr(1'b0, {1'b1, 5'b0, 2'(p)});
      wr(1'b1, 8'd1);
      tick(1);
      n = 1;
      while (!pwm_out && n < 300) begin
        tick(1);
        n++;
      end
      chk("R3 period", n, 1 << (7 - p));
    end

    // R2: no ticks, count holds
    do_reset();
    wr(1'b0, 8'h83);
    wr(1'b1, 8'd5);
    repeat (20) @(negedge clk);
    chk("R2 hold high", int'(pwm_out), 1);
    tick(4);
    chk("R2 step 4 high", int'(pwm_out), 1);
    tick(1);
    chk("R2 step 5 low", int'(pwm_out), 0);

    // R6 / R7: field placement and unused bits
    wr(1'b0, 8'hFF);
    rd(1'b0, v); chk("R6 ctrl readback", v, 8'h83);
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk("R7 duty readback", v, 8'h7F);
    wr(1'b1, 8'h80);
    rd(1'b1, v); chk("R7 bit7 ignored", v, 8'h00);

    // R8: rate change keeps count 40; low 4 bits = 8
    do_reset();
    wr(1'b0, 8'h80);
    wr(1'b1, 8'd8);
    tick(40);
    chk("R8 before switch", int'(pwm_out), 0);
    wr(1'b0, 8'h83);
    chk("R8 after switch", int'(pwm_out), 0);
    tick(7);
    chk("R8 count 47", int'(pwm_out), 0);
    tick(1);
    chk("R8 wrapped to 0", int'(pwm_out), 1);

    // R9: mid-period duty change acts immediately
    do_reset();
    wr(1'b0, 8'h82);
    wr(1'b1, 8'd5);
    tick(10);
    chk("R9 before duty write", int'(pwm_out), 0);
    wr(1'b1, 8'd20);
    chk("R9 after duty write", int'(pwm_out), 1);

    // R10: clearing enable releases the pin
    wr(1'b0, 8'h02);
    chk("R10 pin_own", int'(pin_own), 0);
    chk("R10 pwm_out", int'(pwm_out), 0);
    rd(1'b0, v); chk("R10 ctrl readback", v, 8'h02);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule